// File: doc/BRIEF.md
# Dead-Beat Predictive Current Regulator

This block regulates the output current of a voltage-source inverter with a two-sample dead-beat law. On every sample strobe it takes the measured current, the current set-point and a phase voltage. The phase voltage either comes from a sensor or is reconstructed inside the block from the commands it has already issued and the currents it has already seen. From these it predicts the average voltage for the modulation period after the current one. Because a command is applied one period after it is computed, the closed loop places both poles at the origin. A set-point step is therefore met exactly two samples after it is seen.

The new voltage is the negated command currently being applied, plus the current error scaled by a programmable inductance-over-period gain, plus twice the phase voltage. The result is clamped to a modulator range. It is then scaled by a programmable output gain, which folds together the inverter voltage gain and the transducer gains, to form the modulator command. The reconstructed voltage can be passed through a first-order smoothing filter whose coefficient is a power-of-two shift.

All gains are unsigned with `FRAC` fractional bits. Every product is scaled by 2^-FRAC and rounded toward minus infinity, which is an arithmetic right shift.

Top module: `dbeat_ireg`

## Requirements
- R1: While reset is asserted, `duty`, `duty_vld` and `sat_flag` are zero, and the stored command (current and previous), previous current and filter state are cleared to zero.
- R2: A high `smp_stb` at a rising edge updates `duty` and `sat_flag` at that edge and raises `duty_vld` for exactly the following cycle. Without a strobe, `duty` and `sat_flag` hold and `duty_vld` is low.
- R3: With `est_en`=0, the raw command is V = −Vcur + floor(gain_l·(i_ref − i_meas)/2^FRAC) + 2·v_phase. Vcur is the stored command from the previous sample.
- R4: With `est_en`=1 and `filt_en`=0, the block uses E = Vold − floor(gain_l·(i_meas − Iprev)/2^FRAC) in place of the phase voltage. Vold is the command stored two samples back and Iprev is the previous measured current.
- R5: On every sample the filter state F is updated. With `filt_en`=1, F becomes F + floor((E − F)/2^filt_sh), and with `est_en`=1 this filtered value replaces E in the command. With `filt_en`=0, F is loaded with E.
- R6: The raw command is clamped to ±VMAX and the clamped value is stored as the next Vcur. `sat_flag` is 1 exactly when that sample's raw command lay outside ±VMAX.
- R7: `duty` = floor(Vclamped·gain_out/2^FRAC).
- R8: With a plant I(k+1) = I(k) + (Vapplied − E)·2^FRAC/gain_l, where Vapplied is the command from the previous sample, the current equals a stepped reference from the second sample after the step onward.
- R9: With `est_en`=1, `v_phase` has no effect on `duty` or `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| i_meas | input | IW | Measured current, signed |
| i_ref | input | IW | Current reference, signed |
| v_phase | input | VW | Measured phase voltage, signed |
| gain_l | input | GW | Inductance over period gain, unsigned, FRAC fractional bits |
| gain_out | input | GW | Output normalization gain, unsigned, FRAC fractional bits |
| est_en | input | 1 | 1: use the reconstructed phase voltage |
| filt_en | input | 1 | 1: smooth the reconstructed voltage |
| filt_sh | input | SHW | Filter coefficient as a right-shift count |
| duty | output | OW | Modulator command, signed |
| duty_vld | output | 1 | High for one cycle after each update |
| sat_flag | output | 1 | Last update was clamped |

## Verification
The hardest behaviour to reach from the ports is the exact two-sample convergence. It only appears when the current fed back depends on the commands the block has issued. The bench therefore closes the loop through an integer plant model, with unity inductance gain and a nonzero phase voltage. It then steps the reference and checks the plant current on every later sample. Saturation feedback is reached by driving errors large enough to clamp and then checking the next sample, whose negated-command term must use the clamped value.

// File: rtl/dbeat_ireg.sv
module dbeat_ireg #(
  parameter int IW   = 12,
  parameter int VW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = 10,
  parameter int SHW  = 3,
  parameter int VMAX = 20000,
  localparam int OW  = VW + GW - FRAC + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [IW-1:0] i_meas,
  input  logic signed [IW-1:0] i_ref,
  input  logic signed [VW-1:0] v_phase,
  input  logic        [GW-1:0] gain_l,
  input  logic        [GW-1:0] gain_out,
  input  logic                 est_en,
  input  logic                 filt_en,
  input  logic       [SHW-1:0] filt_sh,
  output logic signed [OW-1:0] duty,
  output logic                 duty_vld,
  output logic                 sat_flag
);
  localparam int SW = GW + IW + VW + 4;
  localparam logic signed [SW-1:0] VHI = SW'(VMAX);
  localparam logic signed [SW-1:0] VLO = -VHI;

  logic signed [VW-1:0] v_cur, v_old;
  logic signed [IW-1:0] i_prev;
  logic signed [SW-1:0] e_f;

  logic signed [SW-1:0] gl, go, err, di, kp, kd, e_est, e_flt, e_use, v_raw, v_sat, dprod;
  logic hi, lo;

  assign gl    = SW'($signed({1'b0, gain_l}));
  assign go    = SW'($signed({1'b0, gain_out}));
  assign err   = SW'(i_ref) - SW'(i_meas);
  assign di    = SW'(i_meas) - SW'(i_prev);
  assign kp    = (gl * err) >>> FRAC;
  assign kd    = (gl * di) >>> FRAC;
  assign e_est = SW'(v_old) - kd;
  assign e_flt = e_f + ((e_est - e_f) >>> filt_sh);
  assign e_use = !est_en ? SW'(v_phase) : (filt_en ? e_flt : e_est);
  assign v_raw = kp - SW'(v_cur) + (e_use <<< 1);
  assign hi    = v_raw > VHI;
  assign lo    = v_raw < VLO;
  assign v_sat = hi ? VHI : (lo ? VLO : v_raw);
  assign dprod = (v_sat * go) >>> FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_cur    <= '0;
      v_old    <= '0;
      i_prev   <= '0;
      e_f      <= '0;
      duty     <= '0;
      duty_vld <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      duty_vld <= smp_stb;
      if (smp_stb) begin
        v_old    <= v_cur;
        v_cur    <= VW'(v_sat);
        i_prev   <= i_meas;
        e_f      <= filt_en ? e_flt : e_est;
        duty     <= OW'(dprod);
        sat_flag <= hi | lo;
      end
    end
  end
endmodule

// File: rtl/dbeat_ireg_chk.sv
module dbeat_ireg_chk #(
  parameter int GW = 16,
  parameter int OW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic [GW-1:0] gain_out,
  input logic [OW-1:0] duty,
  input logic          duty_vld,
  input logic          sat_flag
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (duty == '0 && !duty_vld && !sat_flag));

  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> duty_vld);

  a_r2_no_vld_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !duty_vld);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(duty) && $stable(sat_flag)));

  a_r6_flag_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> duty_vld);

  a_r7_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && gain_out == '0) |=> duty == '0);
endmodule

bind dbeat_ireg dbeat_ireg_chk #(.GW(GW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .gain_out(gain_out),
  .duty(duty), .duty_vld(duty_vld), .sat_flag(sat_flag)
);

// File: tb/dbeat_ireg_tb_top.sv
module dbeat_ireg_tb_top;
  localparam int IW = 12, VW = 16, GW = 16, FRAC = 10, SHW = 3, VMAX = 20000;
  localparam int OW = VW + GW - FRAC + 1;

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0;
  logic signed [IW-1:0] i_meas = '0, i_ref = '0;
  logic signed [VW-1:0] v_phase = '0;
  logic [GW-1:0] gain_l = '0, gain_out = '0;
  logic est_en = 1'b0, filt_en = 1'b0;
  logic [SHW-1:0] filt_sh = '0;
  logic signed [OW-1:0] duty;
  logic duty_vld, sat_flag;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dbeat_ireg #(.IW(IW), .VW(VW), .GW(GW), .FRAC(FRAC), .SHW(SHW), .VMAX(VMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .i_meas(i_meas), .i_ref(i_ref),
    .v_phase(v_phase), .gain_l(gain_l), .gain_out(gain_out), .est_en(est_en),
    .filt_en(filt_en), .filt_sh(filt_sh), .duty(duty), .duty_vld(duty_vld),
    .sat_flag(sat_flag));

  longint m_vcur, m_vold, m_iprev, m_ef;

  localparam int TBL [8][3] = '{
    '{ 100,    0,    0}, '{ 100,   80,   40}, '{-200,  150, -300}, '{   0,    0,    0},
    '{ 500, -500, 1000}, '{-1000, 900, -20}, '{  37,   36,    7}, '{ -45,  -46,   -9}};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_vcur = 0; m_vold = 0; m_iprev = 0; m_ef = 0;
  endtask

  task automatic sample(input longint iref, input longint im, input longint vph,
                        input string tag, output longint d_act);
    longint gl, go, kp, kd, eest, eflt, euse, vr, vs, d_exp;
    bit s_exp;
    gl = longint'(gain_l); go = longint'(gain_out);
    kp = (gl * (iref - im)) >>> FRAC;
    kd = (gl * (im - m_iprev)) >>> FRAC;
    eest = m_vold - kd;
    eflt = m_ef + ((eest - m_ef) >>> filt_sh);
    euse = !est_en ? vph : (filt_en ? eflt : eest);
    vr = -m_vcur + kp + 2 * euse;
    s_exp = (vr > VMAX) || (vr < -VMAX);
    vs = (vr > VMAX) ? VMAX : ((vr < -VMAX) ? -VMAX : vr);
    m_ef = filt_en ? eflt : eest;
    m_vold = m_vcur; m_vcur = vs; m_iprev = im;
    d_exp = (vs * go) >>> FRAC;
    @(negedge clk);
    i_ref = IW'(iref); i_meas = IW'(im); v_phase = VW'(vph); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    d_act = longint'(duty);
    chk(duty_vld == 1'b1, {tag, " R2 vld"}, duty_vld, 1);
    chk(d_act == d_exp, {tag, " duty"}, d_act, d_exp);
    chk(sat_flag == s_exp, {tag, " R6 sat"}, sat_flag, s_exp);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint d, hold, ip, iref_s, vapp;
    gain_l = 16'd1536; gain_out = 16'd512;
    do_reset();
    // R1 reset state
    chk(duty == '0 && !duty_vld && !sat_flag, "R1 reset outputs", duty, 0);

    // R3 R7 table walk, measured voltage
    for (int n = 0; n < 8; n++)
      sample(TBL[n][0], TBL[n][1], TBL[n][2], "R3 R7 table", d);

    // R2 hold without strobe
    hold = longint'(duty);
    repeat (4) @(negedge clk);
    chk(longint'(duty) == hold, "R2 hold duty", duty, hold);
    chk(duty_vld == 1'b0, "R2 vld low", duty_vld, 0);

    // R6 saturation both ways, clamped value fed back
    sample(2000, -2000, 8000, "R6 high", d);
    sample(-2000, 2000, -8000, "R6 low", d);
    sample(0, 0, 0, "R6 feedback", d);

    // R7 zero output gain
    gain_out = '0;
    sample(300, 0, 50, "R7 zero gain", d);
    gain_out = 16'd1024;

    // R4 R9 estimator, v_phase varied wildly
    do_reset();
    est_en = 1'b1;
    sample(200, 10, 12345, "R4 R9 est a", d);
    sample(200, 60, -30000, "R4 R9 est b", d);
    sample(-100, 90, 777, "R4 R9 est c", d);
    sample(50, -40, -1, "R4 R9 est d", d);

    // R9 direct: same history, different v_phase, same duty
    begin
      longint d1, d2;
      do_reset();
      sample(120, 30, 100, "R9 run1 a", d);
      sample(-60, 70, 100, "R9 run1 b", d1);
      do_reset();
      sample(120, 30, -9000, "R9 run2 a", d);
      sample(-60, 70, 9000, "R9 run2 b", d2);
      chk(d1 == d2, "R9 v_phase ignored", d2, d1);
    end

    // R5 filter
    filt_en = 1'b1; filt_sh = 3'd2;
    for (int n = 0; n < 5; n++)
      sample(150 - 40 * n, 20 * n - 30, 0, "R5 filter", d);
    filt_sh = 3'd0;
    sample(10, 5, 0, "R5 filter sh0", d);
    filt_en = 1'b0; est_en = 1'b0;

    // R8 closed loop dead-beat with unity inductance gain
    do_reset();
    gain_l = 16'd1024; gain_out = 16'd1024;
    ip = 0; vapp = 0; iref_s = 300;
    for (int k = 0; k < 7; k++) begin
      if (k >= 2) chk(ip == iref_s, "R8 dead-beat current", ip, iref_s);
      sample(iref_s, ip, 50, "R8 loop", d);
      ip = ip + vapp - 50;
      vapp = d;
    end
    iref_s = -150;
    for (int k = 0; k < 6; k++) begin
      if (k >= 2) chk(ip == iref_s, "R8 dead-beat step down", ip, iref_s);
      sample(iref_s, ip, 50, "R8 loop2", d);
      ip = ip + vapp - 50;
      vapp = d;
    end

    // R1 reset clears stored state: first sample uses zero history
    est_en = 1'b1;
    do_reset();
    chk(duty == '0 && !sat_flag, "R1 reset after use", duty, 0);
    sample(0, 0, 0, "R1 zero history", d);
    chk(d == 0, "R1 cleared state", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule